// File: doc/BRIEF.md
# Slow-Control Status and Control Register Bank

This block is a bank of 32-bit registers on a simple slow-control bus. The bus has an address, write data, a read strobe, a write strobe, an acknowledge and an unknown-address flag. Software polls two status words. The first packs the board's error and warning flags with a 12-bit temperature. The second packs two 16-bit trigger counters, which live inside the block and count input pulses.

On the control side, one register issues single-cycle strobes when written. These strobes drive user-logic resets, a sequence-counter reset, a reboot request and sixteen test triggers. A second control register holds its value and loads the level-1 trigger counter. A third loads a free-running global-time counter. A separate counter measures the clocks since the last timing trigger.

A small information memory of 16-bit entries is read and written as packed 32-bit words. Every access is answered one cycle after its strobe, either with an acknowledge or with the unknown-address flag.

Top module: `slowctl_regbank`

## Requirements
- R1: A read of 0x00 returns the flags in bits 5:0 (bit 0 serious error, bit 1 error, bit 2 warning, bit 3 info, bit 4 trigger-1 mismatch, bit 5 trigger-2 mismatch), the 12-bit temperature in bits 31:20 (bits 23:20 are its fraction) and zeros in bits 19:6.
- R2: A read of 0x01 returns the level-1 counter in bits 15:0 and the level-2 counter in bits 31:16.
- R3: Each trigger counter adds one in every clock its trigger input is high, and wraps from 0xFFFF to 0.
- R4: A write to 0x20 puts the written word on strobe_o for exactly the cycle of the acknowledge, after which strobe_o returns to zero. Bits 3:0 are user-logic resets, bit 10 resets the sequence counter, bit 15 requests a reboot, and bits 31:16 are test triggers 0 to 15. A read of 0x20 returns zero.
- R5: A write to 0x21 loads data bits 15:0 into the level-1 counter, and this load wins over a trigger pulse in the same cycle. A read of 0x21 returns the whole last written word.
- R6: The global-time counter adds one every clock. A write to 0x22 loads it with the data. A read of 0x50 returns the count, and a read of 0x22 returns the last written word.
- R7: The counter read at 0x51 is zero after a clock with the timing trigger high, and otherwise adds one every clock.
- R8: A write to 0x40+k stores data bits 15:0 into entry 2k and data bits 31:16 into entry 2k+1, for k from 0 to 3. A read of 0x40+k returns {entry 2k+1, entry 2k}.
- R9: Every access to a mapped address raises ack_o for one cycle, in the cycle after the strobe, and read data is valid in that same cycle. An access to any other address raises unk_o instead, with rdata_o zero. With no access, both flags are low.
- R10: Writes to 0x00, 0x01, 0x50 and 0x51 are acknowledged and change nothing.
- R11: After reset, every counter, register, memory entry and output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 32 | Write data |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| rdata_o | output | 32 | Read data, valid with ack_o |
| ack_o | output | 1 | Access acknowledged |
| unk_o | output | 1 | Access hit an unmapped address |
| flags_i | input | 6 | Error, warning and mismatch flags |
| temp_i | input | 12 | Temperature, low 4 bits fractional |
| lvl1_trig_i | input | 1 | Level-1 trigger pulse |
| lvl2_trig_i | input | 1 | Level-2 trigger pulse |
| timing_trig_i | input | 1 | Timing trigger pulse |
| strobe_o | output | 32 | Self-clearing control strobes |

## Verification
A counter that slips by one, or misses a load, shows up as a wrong field on the next read of 0x01, 0x50 or 0x51. The reference model reads these back after each relevant stimulus, so such a fault is exposed within a few cycles. A strobe that fails to clear is visible on strobe_o one cycle after the acknowledge. A decode error shows as a misplaced ack_o or unk_o in the cycle right after the strobe. The bench compares every output on every clock, so any deviation is caught in the cycle it first appears.

// File: rtl/slowctl_pkg.sv
package slowctl_pkg;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 16;
  localparam int TEMP_W = 12;
  localparam int FLAG_W = 6;

  localparam logic [7:0] A_STAT0  = 8'h00;
  localparam logic [7:0] A_STAT1  = 8'h01;
  localparam logic [7:0] A_STROBE = 8'h20;
  localparam logic [7:0] A_CTRL1  = 8'h21;
  localparam logic [7:0] A_GTSET  = 8'h22;
  localparam logic [7:0] A_INFO   = 8'h40;
  localparam logic [7:0] A_GTIME  = 8'h50;
  localparam logic [7:0] A_TSINCE = 8'h51;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_STAT0, SEL_STAT1, SEL_STROBE, SEL_CTRL1,
    SEL_GTSET, SEL_INFO, SEL_GTIME, SEL_TSINCE
  } sel_e;
endpackage

// File: rtl/slowctl_decode.sv
module slowctl_decode
  import slowctl_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int INFO_WORDS = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  output sel_e              sel_o
);
  localparam logic [ADDR_W-1:0] INFO_LO = ADDR_W'(A_INFO);
  localparam logic [ADDR_W-1:0] INFO_HI = ADDR_W'(A_INFO) + ADDR_W'(INFO_WORDS);

  always_comb begin
    sel_o = SEL_NONE;
    if (addr_i == ADDR_W'(A_STAT0))                   sel_o = SEL_STAT0;
    else if (addr_i == ADDR_W'(A_STAT1))              sel_o = SEL_STAT1;
    else if (addr_i == ADDR_W'(A_STROBE))             sel_o = SEL_STROBE;
    else if (addr_i == ADDR_W'(A_CTRL1))              sel_o = SEL_CTRL1;
    else if (addr_i == ADDR_W'(A_GTSET))              sel_o = SEL_GTSET;
    else if (addr_i == ADDR_W'(A_GTIME))              sel_o = SEL_GTIME;
    else if (addr_i == ADDR_W'(A_TSINCE))             sel_o = SEL_TSINCE;
    else if (addr_i >= INFO_LO && addr_i < INFO_HI)   sel_o = SEL_INFO;
  end
endmodule

// File: rtl/slowctl_counter.sv
module slowctl_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] q_o
);
  // load beats clear beats increment
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (ld_i)   q_o <= ld_val_i;
    else if (clr_i)  q_o <= '0;
    else if (inc_i)  q_o <= q_o + W'(1);
  end
endmodule

// File: rtl/slowctl_info.sv
module slowctl_info #(
  parameter int DEPTH = 8,
  parameter int HW    = 16,
  localparam int WORDS = DEPTH / 2,
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [2*HW-1:0]   wdata_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [2*HW-1:0]   rdata_o
);
  // word w packs entry 2w (low half) and entry 2w+1 (high half)
  logic [2*HW-1:0] word_q [WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < WORDS; w++) word_q[w] <= '0;
    end else if (we_i) begin
      for (int w = 0; w < WORDS; w++)
        if (widx_i == IDX_W'(w)) word_q[w] <= wdata_i;
    end
  end

  assign rdata_o = word_q[ridx_i];
endmodule

// File: rtl/slowctl_regbank.sv
module slowctl_regbank
  import slowctl_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int INFO_DEPTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output logic [31:0]       rdata_o,
  output logic              ack_o,
  output logic              unk_o,
  input  logic [5:0]        flags_i,
  input  logic [11:0]       temp_i,
  input  logic              lvl1_trig_i,
  input  logic              lvl2_trig_i,
  input  logic              timing_trig_i,
  output logic [31:0]       strobe_o
);
  localparam int INFO_WORDS = INFO_DEPTH / 2;
  localparam int IDX_W      = (INFO_WORDS > 1) ? $clog2(INFO_WORDS) : 1;
  localparam int PAD_W      = DATA_W - TEMP_W - FLAG_W;

  sel_e              sel;
  logic              hit;
  logic [CNT_W-1:0]  lvl1_q, lvl2_q;
  logic [DATA_W-1:0] gtime_q, tsince_q, info_rd, rd_mux;
  logic [DATA_W-1:0] ctrl1_q, gtset_q;
  logic              ld_lvl1, ld_gtime, we_info;

  slowctl_decode #(.ADDR_W(ADDR_W), .INFO_WORDS(INFO_WORDS)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  assign hit      = (sel != SEL_NONE);
  assign ld_lvl1  = wr_i && (sel == SEL_CTRL1);
  assign ld_gtime = wr_i && (sel == SEL_GTSET);
  assign we_info  = wr_i && (sel == SEL_INFO);

  slowctl_counter #(.W(CNT_W)) u_lvl1 (
    .clk_i, .rst_ni, .ld_i(ld_lvl1), .ld_val_i(wdata_i[CNT_W-1:0]),
    .clr_i(1'b0), .inc_i(lvl1_trig_i), .q_o(lvl1_q)
  );

  slowctl_counter #(.W(CNT_W)) u_lvl2 (
    .clk_i, .rst_ni, .ld_i(1'b0), .ld_val_i('0),
    .clr_i(1'b0), .inc_i(lvl2_trig_i), .q_o(lvl2_q)
  );

  slowctl_counter #(.W(DATA_W)) u_gtime (
    .clk_i, .rst_ni, .ld_i(ld_gtime), .ld_val_i(wdata_i),
    .clr_i(1'b0), .inc_i(1'b1), .q_o(gtime_q)
  );

  slowctl_counter #(.W(DATA_W)) u_tsince (
    .clk_i, .rst_ni, .ld_i(1'b0), .ld_val_i('0),
    .clr_i(timing_trig_i), .inc_i(1'b1), .q_o(tsince_q)
  );

  slowctl_info #(.DEPTH(INFO_DEPTH), .HW(DATA_W/2)) u_info (
    .clk_i, .rst_ni, .we_i(we_info), .widx_i(addr_i[IDX_W-1:0]),
    .wdata_i(wdata_i), .ridx_i(addr_i[IDX_W-1:0]), .rdata_o(info_rd)
  );

  always_comb begin
    case (sel)
      SEL_STAT0:  rd_mux = {temp_i, {PAD_W{1'b0}}, flags_i};
      SEL_STAT1:  rd_mux = {lvl2_q, lvl1_q};
      SEL_CTRL1:  rd_mux = ctrl1_q;
      SEL_GTSET:  rd_mux = gtset_q;
      SEL_INFO:   rd_mux = info_rd;
      SEL_GTIME:  rd_mux = gtime_q;
      SEL_TSINCE: rd_mux = tsince_q;
      default:    rd_mux = '0;  // strobe register reads as zero
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o    <= 1'b0;
      unk_o    <= 1'b0;
      rdata_o  <= '0;
      strobe_o <= '0;
      ctrl1_q  <= '0;
      gtset_q  <= '0;
    end else begin
      ack_o    <= (rd_i || wr_i) && hit;
      unk_o    <= (rd_i || wr_i) && !hit;
      rdata_o  <= (rd_i && hit) ? rd_mux : '0;
      strobe_o <= (wr_i && sel == SEL_STROBE) ? wdata_i : '0;
      if (ld_lvl1)  ctrl1_q <= wdata_i;
      if (ld_gtime) gtset_q <= wdata_i;
    end
  end
endmodule

// File: rtl/slowctl_regbank_chk.sv
module slowctl_regbank_chk
  import slowctl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic              ack_o,
  input logic              unk_o,
  input logic [31:0]       strobe_o,
  input logic              lvl1_trig_i,
  input logic              lvl2_trig_i,
  input logic              timing_trig_i,
  input logic [15:0]       lvl1_q,
  input logic [15:0]       lvl2_q,
  input logic [31:0]       tsince_q
);
  logic wr_strobe, wr_ctrl1;
  assign wr_strobe = wr_i && (addr_i == ADDR_W'(A_STROBE));
  assign wr_ctrl1  = wr_i && (addr_i == ADDR_W'(A_CTRL1));

  p_strobe_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_strobe |=> strobe_o == $past(wdata_i));

  p_strobe_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_strobe |=> strobe_o == '0);

  p_answer_next_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i || wr_i) |=> (ack_o != unk_o));

  p_quiet_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i || wr_i) |=> (!ack_o && !unk_o));

  p_lvl1_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl1 |=> lvl1_q == $past(wdata_i[15:0]));

  p_lvl1_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl1_trig_i && !wr_ctrl1) |=> lvl1_q == 16'($past(lvl1_q) + 16'd1));

  p_lvl2_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl2_trig_i |=> lvl2_q == 16'($past(lvl2_q) + 16'd1));

  p_tsince_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timing_trig_i |=> tsince_q == '0);
endmodule

bind slowctl_regbank slowctl_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .addr_i        (addr_i),
  .wdata_i       (wdata_i),
  .rd_i          (rd_i),
  .wr_i          (wr_i),
  .ack_o         (ack_o),
  .unk_o         (unk_o),
  .strobe_o      (strobe_o),
  .lvl1_trig_i   (lvl1_trig_i),
  .lvl2_trig_i   (lvl2_trig_i),
  .timing_trig_i (timing_trig_i),
  .lvl1_q        (lvl1_q),
  .lvl2_q        (lvl2_q),
  .tsince_q      (tsince_q)
);

// File: tb/slowctl_regbank_test.sv
`timescale 1ns/1ps
module slowctl_regbank_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [31:0] rdata, strobe;
  logic        ack, unk;
  logic [5:0]  flags = '0;
  logic [11:0] temp = '0;
  logic        t1 = 1'b0, t2 = 1'b0, tt = 1'b0;

  int    checks = 0, errors = 0, cyc = 0;
  bit    run = 1'b0, done = 1'b0;
  string phase = "";

  always #2 clk = ~clk;

  slowctl_regbank uut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wdata_i(wdata),
    .rd_i(rd), .wr_i(wr), .rdata_o(rdata), .ack_o(ack), .unk_o(unk),
    .flags_i(flags), .temp_i(temp), .lvl1_trig_i(t1), .lvl2_trig_i(t2),
    .timing_trig_i(tt), .strobe_o(strobe)
  );

  // behavioural reference model
  logic [15:0] m_l1 = '0, m_l2 = '0;
  logic [31:0] m_ctrl1 = '0, m_gtset = '0, m_gtime = '0, m_ts = '0;
  logic [15:0] m_info [8];
  logic [31:0] e_rdata = '0, e_strobe = '0;
  logic        e_ack = 1'b0, e_unk = 1'b0;
  string       e_tag = "R9";

  function automatic bit mapped(input logic [7:0] a);
    return a == 8'h00 || a == 8'h01 || a == 8'h20 || a == 8'h21 || a == 8'h22 ||
           (a >= 8'h40 && a <= 8'h43) || a == 8'h50 || a == 8'h51;
  endfunction

  function automatic logic [31:0] model_read(input logic [7:0] a);
    int k;
    k = int'(a) - 'h40;
    case (a)
      8'h00: return {temp, 14'd0, flags};
      8'h01: return {m_l2, m_l1};
      8'h21: return m_ctrl1;
      8'h22: return m_gtset;
      8'h50: return m_gtime;
      8'h51: return m_ts;
      8'h40, 8'h41, 8'h42, 8'h43: return {m_info[2*k+1], m_info[2*k]};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    if (phase != "") return phase;
    case (a)
      8'h00: return "R1";
      8'h01: return "R2";
      8'h20: return "R4";
      8'h21: return "R5";
      8'h22, 8'h50: return "R6";
      8'h51: return "R7";
      8'h40, 8'h41, 8'h42, 8'h43: return "R8";
      default: return "R9";
    endcase
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_l1 = '0; m_l2 = '0; m_ctrl1 = '0; m_gtset = '0; m_gtime = '0; m_ts = '0;
      for (int i = 0; i < 8; i++) m_info[i] = '0;
      e_rdata = '0; e_strobe = '0; e_ack = 1'b0; e_unk = 1'b0; e_tag = "R11";
    end else begin
      e_ack    = (rd || wr) && mapped(addr);
      e_unk    = (rd || wr) && !mapped(addr);
      e_rdata  = (rd && mapped(addr)) ? model_read(addr) : 32'd0;
      e_strobe = (wr && addr == 8'h20) ? wdata : 32'd0;
      e_tag    = tag_of(addr);
      if (wr && addr == 8'h21) begin m_l1 = wdata[15:0]; m_ctrl1 = wdata; end
      else if (t1) m_l1 = m_l1 + 16'd1;
      if (t2) m_l2 = m_l2 + 16'd1;
      if (wr && addr == 8'h22) begin m_gtime = wdata; m_gtset = wdata; end
      else m_gtime = m_gtime + 32'd1;
      m_ts = tt ? 32'd0 : m_ts + 32'd1;
      if (wr && addr >= 8'h40 && addr <= 8'h43) begin
        m_info[2*(int'(addr)-'h40)]   = wdata[15:0];
        m_info[2*(int'(addr)-'h40)+1] = wdata[31:16];
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (run && rst_ni) begin
      chk(ack === e_ack, "R9 ack", 32'(ack), 32'(e_ack));
      chk(unk === e_unk, "R9 unk", 32'(unk), 32'(e_unk));
      chk(strobe === e_strobe, "R4 strobe", strobe, e_strobe);
      chk(rdata === e_rdata, e_tag, rdata, e_rdata);
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      finish_run();
    end
  end

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    // R11: reset state at the ports
    chk(rdata === 32'd0 && ack === 1'b0 && unk === 1'b0, "R11 bus", rdata, 32'd0);
    chk(strobe === 32'd0, "R11 strobe", strobe, 32'd0);
    rst_ni = 1'b1;
    run = 1'b1;
    bus_rd(8'h51);  // R11 time-since counter starts from zero
    bus_rd(8'h01);  // R11 trigger counters zero

    // R1 status word layout, two patterns
    flags = 6'h2B; temp = 12'hA5C;
    bus_rd(8'h00);
    flags = 6'h14; temp = 12'h3F1;
    bus_rd(8'h00);

    // R3 / R2 counters
    phase = "R3";
    @(negedge clk); t1 = 1'b1;
    idle(3); t1 = 1'b0; t2 = 1'b1;
    idle(2); t2 = 1'b0;
    phase = "";
    bus_rd(8'h01);

    // R4 strobes
    bus_wr(8'h20, 32'hABCD_8405);
    idle(1);
    chk(strobe === 32'd0, "R4 cleared", strobe, 32'd0);
    bus_wr(8'h20, 32'h0001_000F);
    bus_rd(8'h20);

    // R5 counter load, wrap, priority
    bus_wr(8'h21, 32'h0000_FFFF);
    phase = "R3";
    @(negedge clk); t1 = 1'b1;
    @(negedge clk); t1 = 1'b0;
    bus_rd(8'h01);  // level-1 wrapped to 0
    phase = "";
    @(negedge clk); addr = 8'h21; wdata = 32'h1234_0100; wr = 1'b1; t1 = 1'b1;
    @(negedge clk); wr = 1'b0; t1 = 1'b0;
    bus_rd(8'h01);
    bus_rd(8'h21);

    // R6 global time
    bus_wr(8'h22, 32'h1000_0000);
    idle(5);
    bus_rd(8'h50);
    bus_rd(8'h22);
    bus_wr(8'h22, 32'hFFFF_FFFE);
    bus_rd(8'h50);

    // R7 time since trigger
    @(negedge clk); tt = 1'b1;
    @(negedge clk); tt = 1'b0;
    idle(3);
    bus_rd(8'h51);
    @(negedge clk); addr = 8'h51; rd = 1'b1; tt = 1'b1;
    @(negedge clk); rd = 1'b0; tt = 1'b0;
    bus_rd(8'h51);

    // R8 information memory
    bus_wr(8'h40, 32'h1111_0000);
    bus_wr(8'h41, 32'h3333_2222);
    bus_wr(8'h42, 32'h5555_4444);
    bus_wr(8'h43, 32'h7777_6666);
    bus_rd(8'h42);
    bus_rd(8'h40);
    bus_rd(8'h43);
    bus_wr(8'h41, 32'hBEEF_CAFE);
    bus_rd(8'h41);

    // R9 unmapped accesses
    bus_rd(8'h30);
    bus_wr(8'h7F, 32'hFFFF_FFFF);
    bus_rd(8'h44);
    bus_rd(8'h02);

    // R10 writes to read-only words change nothing
    phase = "R10";
    bus_wr(8'h00, 32'hFFFF_FFFF);
    bus_wr(8'h01, 32'hFFFF_FFFF);
    bus_wr(8'h50, 32'h0000_0000);
    bus_wr(8'h51, 32'hFFFF_FFFF);
    bus_rd(8'h00);
    bus_rd(8'h01);
    bus_rd(8'h50);
    bus_rd(8'h51);
    phase = "";

    // R3 level-2 wrap over a full period
    phase = "R3";
    @(negedge clk); t2 = 1'b1;
    repeat (65536) @(negedge clk);
    t2 = 1'b0;
    phase = "";
    bus_rd(8'h01);
    idle(2);

    finish_run();
  end
endmodule